// File: doc/BRIEF.md
# Burst Address Counter With Repeat

This block generates the address for one port of a synchronous memory. A strobe captures an address supplied from outside. Later cycles can then step that address up by one per cycle to walk through a burst. The block also keeps a copy of the last strobed address. A repeat request uses that copy to restart the burst from its first location, so the address does not have to be driven again.

All controls are active low and are sampled on the rising edge of the port clock. The address seen by the memory array comes straight from the counter register. It therefore shows the effect of a command in the cycle after the edge that sampled it. When more than one control is active, a fixed priority decides which command runs. Reset is synchronous and active low.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both the counter and the saved base address become zero. The first repeat after reset therefore gives address 0.
- R2: With `strobe_n` low at a rising edge, `addr` equals the `ext_addr` value sampled at that edge, one cycle later.
- R3: With only `incr_n` low at a rising edge, `addr` becomes its previous value plus one.
- R4: With `rpt_n` low and `strobe_n` high at a rising edge, `addr` becomes the `ext_addr` value captured by the most recent strobe.
- R5: A strobe wins over repeat and over increment when they are asserted in the same cycle.
- R6: A repeat wins over an increment when both are asserted in the same cycle without a strobe.
- R7: With all three controls high, `addr` keeps its value.
- R8: An increment from the all-ones address gives address zero.
- R9: Increment and repeat leave the saved base address unchanged. Only a strobe replaces it.
- R10: The address width is the parameter `ADDR_W` (default 18). Wrap-around and loading follow that width, for example 17 bits for a half-depth array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_addr | input | ADDR_W | Address supplied from outside, captured on a strobe |
| strobe_n | input | 1 | Load `ext_addr` into counter and base, active low |
| incr_n | input | 1 | Advance the counter by one, active low |
| rpt_n | input | 1 | Reload the counter from the saved base, active low |
| addr | output | ADDR_W | Current address presented to the memory array |

## Verification
The checker assumes that every control and `ext_addr` is settled at each rising edge and never X. It also assumes that the base register it observes changes only through the strobe path. The bench changes inputs only on falling edges and drives every control to a known level from time zero, so these assumptions hold. The stimulus deliberately asserts controls together so that both priority orders run. It also crosses the all-ones boundary in both the 18-bit and the 17-bit configuration.

// File: rtl/burst_addr_pkg.sv
// Shared definitions for the burst address generator.
// Assumes: nothing beyond IEEE 1800-2017.
package burst_addr_pkg;

    // Command resolved from the three active-low controls
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_BACK = 2'd2,
        CMD_LOAD = 2'd3
    } burst_cmd_e;

endpackage

// File: rtl/burst_cmd_arb.sv
// Resolves the active-low strobe, repeat and increment controls into one
// command. Order of precedence: strobe, then repeat, then increment.
// Assumes: inputs are already synchronous to the port clock.
module burst_cmd_arb
    import burst_addr_pkg::*;
(
    input  logic       strobe_n,
    input  logic       rpt_n,
    input  logic       incr_n,
    output burst_cmd_e cmd
);

    // Priority select of the command for this cycle
    always_comb begin
        if (!strobe_n) begin
            cmd = CMD_LOAD;
        end else if (!rpt_n) begin
            cmd = CMD_BACK;
        end else if (!incr_n) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end

endmodule

// File: rtl/burst_base_reg.sv
// Holds the address captured by the most recent strobe, for use by repeat.
// Assumes: load is high only for a strobe; rst_n is synchronous, active low.
module burst_base_reg #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);

    // Capture the strobed address; hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/burst_addr_cnt.sv
// The address counter register. It loads, reloads from the base, steps by
// one with wrap, or holds, as the resolved command selects.
// Assumes: cmd comes from burst_cmd_arb; rst_n is synchronous, active low.
module burst_addr_cnt
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  burst_cmd_e        cmd,
    input  logic [ADDR_W-1:0] ext,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] q
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] nxt;

    // Choose the next counter value from the command
    always_comb begin
        unique case (cmd)
            CMD_LOAD: nxt = ext;
            CMD_BACK: nxt = base;
            CMD_STEP: nxt = q + ONE;
            default:  nxt = q;
        endcase
    end

    // Register the counter value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Per-port burst address generator. It captures an address on a strobe,
// steps it on increment, and returns to the strobed address on repeat.
// Assumes: all inputs are synchronous to clk; rst_n is synchronous, active low.
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_n,
    input  logic              incr_n,
    input  logic              rpt_n,
    output logic [ADDR_W-1:0] addr
);

    burst_cmd_e        cmd;
    logic [ADDR_W-1:0] base_q;

    burst_cmd_arb u_arb (
        .strobe_n (strobe_n),
        .rpt_n    (rpt_n),
        .incr_n   (incr_n),
        .cmd      (cmd)
    );

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmd == CMD_LOAD),
        .d     (ext_addr),
        .q     (base_q)
    );

    burst_addr_cnt #(.ADDR_W(ADDR_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .ext   (ext_addr),
        .base  (base_q),
        .q     (addr)
    );

endmodule

// File: rtl/burst_addr_gen_chk.sv
// Checker for burst_addr_gen, bound into every instance of it.
// Assumes: inputs are known at each rising edge.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              strobe_n,
    input logic              incr_n,
    input logic              rpt_n,
    input logic [ADDR_W-1:0] addr,
    input logic [ADDR_W-1:0] base_q
);

    // R1: both registers are zero on the first cycle out of reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (addr == '0 && base_q == '0));

    // R2 and R5: a strobe loads the external address, whatever else is asserted
    a_r2_strobe_load: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |=> addr == $past(ext_addr));

    // R4 and R6: a repeat without a strobe returns to the saved base
    a_r4_repeat_base: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_n && !rpt_n) |=> addr == $past(base_q));

    // R3 and R8: an increment on its own adds one, modulo the width
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_n && rpt_n && !incr_n) |=> addr == ADDR_W'($past(addr) + 1'b1));

    // R7: with no control asserted the address holds
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_n && rpt_n && incr_n) |=> $stable(addr));

    // R9: without a strobe the saved base does not change
    a_r9_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_n |=> $stable(base_q));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_addr (ext_addr),
    .strobe_n (strobe_n),
    .incr_n   (incr_n),
    .rpt_n    (rpt_n),
    .addr     (addr),
    .base_q   (base_q)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;

    localparam int AW  = 18;
    localparam int AWH = 17;
    localparam int NV  = 12;

    // Vector layout: [38] strobe_n, [37] rpt_n, [36] incr_n,
    // [35:18] ext_addr, [17:0] expected addr after the edge
    localparam logic [38:0] VEC [NV] = '{
        {3'b011, 18'h00100, 18'h00100},  // R2 load
        {3'b110, 18'h3FFFF, 18'h00101},  // R3 step
        {3'b110, 18'h00000, 18'h00102},  // R3 step
        {3'b111, 18'h12345, 18'h00102},  // R7 idle hold
        {3'b101, 18'h00000, 18'h00100},  // R4 repeat
        {3'b100, 18'h00000, 18'h00100},  // R6 repeat beats step
        {3'b110, 18'h00000, 18'h00101},  // R3 step
        {3'b000, 18'h2ABCD, 18'h2ABCD},  // R5 strobe beats all
        {3'b010, 18'h3FFFF, 18'h3FFFF},  // R5 strobe beats step
        {3'b110, 18'h00000, 18'h00000},  // R8 wrap
        {3'b110, 18'h00000, 18'h00001},  // R3 step after wrap
        {3'b101, 18'h00000, 18'h3FFFF}   // R9 base kept through steps
    };
    localparam int VREQ [NV] = '{2, 3, 3, 7, 4, 6, 3, 5, 5, 8, 3, 9};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [AW-1:0]  ext_addr = '0;
    logic           strobe_n = 1'b1;
    logic           incr_n = 1'b1;
    logic           rpt_n = 1'b1;
    logic [AW-1:0]  addr;

    logic [AWH-1:0] ext_h = '0;
    logic           strobe_h = 1'b1;
    logic           incr_h = 1'b1;
    logic           rpt_h = 1'b1;
    logic [AWH-1:0] addr_h;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
        .strobe_n(strobe_n), .incr_n(incr_n), .rpt_n(rpt_n), .addr(addr)
    );

    burst_addr_gen #(.ADDR_W(AWH)) uut_half (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_h),
        .strobe_n(strobe_h), .incr_n(incr_h), .rpt_n(rpt_h), .addr(addr_h)
    );

    task automatic check(input string req, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive on a falling edge; the result is sampled on the next falling edge
    task automatic step(input logic s, input logic r, input logic i,
                        input logic [AW-1:0] a);
        strobe_n = s; rpt_n = r; incr_n = i; ext_addr = a;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset addr", addr, '0);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            step(VEC[k][38], VEC[k][37], VEC[k][36], VEC[k][35:18]);
            check($sformatf("R%0d vector %0d", VREQ[k], k), addr, VEC[k][17:0]);
        end
        // R1: reset wins over a strobe and clears the saved base
        step(1'b1, 1'b1, 1'b1, '0);
        rst_n = 1'b0;
        step(1'b0, 1'b1, 1'b1, 18'h15555);
        check("R1 reset over strobe", addr, '0);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b1, '0);
        check("R1 base cleared", addr, '0);
        // R10: 17-bit variant loads and wraps at its own width
        strobe_h = 1'b0; ext_h = 17'h1FFFF;
        @(negedge clk);
        check("R10 half load", AW'(addr_h), 18'h1FFFF);
        strobe_h = 1'b1; incr_h = 1'b0;
        @(negedge clk);
        check("R10 half wrap", AW'(addr_h), '0);
        incr_h = 1'b1; rpt_h = 1'b0;
        @(negedge clk);
        check("R10 half repeat", AW'(addr_h), 18'h1FFFF);
        rpt_h = 1'b1;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(20 * 10000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule